// File: doc/BRIEF.md
# Synchronized SDRAM Refresh Timer

This block keeps time for periodic auto-refresh in a memory controller that shares one SDRAM command bus with other controllers of the same kind. A down-counter measures a refresh interval picked from four fixed cycle counts. When the interval runs out, the block raises a refresh request. If it owns the bus, it then runs a short command sequence: it stops an open burst if needed, precharges all banks and issues a single auto-refresh. After that it keeps the bus quiet for the whole refresh cycle.

A controller that does not own the bus only watches the shared command pins. Each auto-refresh it sees there restarts its own interval, so every controller on the bus counts from the same moment. When it sees a self-refresh entry, its counter stops for as long as clock-enable stays low. An expiry that falls while the block is not bus master is held as a pending request and served once mastership returns. When the busy flag drops after a refresh, every row is closed, so the data path must open its next access with a fresh activate. Burst data transfer belongs to the data path and is not part of this block.

Top module: `sdram_refresh_sync`

## Requirements
- R1: The field `rate_sel` sets the refresh interval: 2'b00 = 600, 2'b01 = 900, 2'b10 = 1200, 2'b11 = 2400 clock cycles. Successive refreshes of a master that sees `bus_idle` high are exactly that many cycles apart.
- R2: `rfsh_req` rises in the cycle after the interval expires. It stays high until the block issues its refresh, or until a slave observes a refresh on the bus, and it falls in the cycle after that event.
- R3: If `bus_idle` is low when the sequence starts, the block drives one burst-stop (cs_n=0, ras_n=1, cas_n=1, we_n=0) in the cycle after `rfsh_req` rises. It then drives no command until `bus_idle` is sampled high. If `bus_idle` is already high, the burst-stop is skipped.
- R4: The precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1) is driven in the cycle after the sequence may start (`bus_idle` high). The auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, a10=1) follows exactly TRP cycles after the precharge-all.
- R5: After the auto-refresh the block drives only no-operation (cs_n=1) for TRC-1 = TRAS+TRP-1 cycles. `busy` falls exactly TRC cycles after the auto-refresh.
- R6: Each pending request yields exactly one auto-refresh. Expiries that occur while a request is already pending merge into it.
- R7: While `is_master` is low, `cmd_oe` stays low and the block drives no command.
- R8: In slave mode, an auto-refresh decoded on the snooped pins with clock-enable high in this cycle and the last one reloads the interval: the next expiry comes exactly one interval later. The same event clears a pending request.
- R9: A self-refresh entry (auto-refresh encoding with snooped clock-enable high in the last cycle and low in this one) freezes the counter. It does not advance on any clock edge where snooped clock-enable is low.
- R10: A request pending while the block is slave starts the sequence when `is_master` rises: the precharge-all is driven in the next cycle if `bus_idle` is high.
- R11: During and right after reset, `rfsh_req`, `busy` and `cmd_oe` are low and the command pins show no-operation (cs_n=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Refresh interval select |
| is_master | input | 1 | High while this controller owns the command bus |
| bus_idle | input | 1 | High when no burst is open on the data path |
| snp_cke | input | 1 | Snooped clock-enable of the shared bus |
| snp_cs_n | input | 1 | Snooped chip select |
| snp_ras_n | input | 1 | Snooped row strobe |
| snp_cas_n | input | 1 | Snooped column strobe |
| snp_we_n | input | 1 | Snooped write enable |
| rfsh_req | output | 1 | Refresh is due and not yet served |
| busy | output | 1 | Refresh sequence in progress |
| cmd_oe | output | 1 | Drive enable for the command pins below |
| cmd_cs_n | output | 1 | Chip select |
| cmd_ras_n | output | 1 | Row strobe |
| cmd_cas_n | output | 1 | Column strobe |
| cmd_we_n | output | 1 | Write enable |
| cmd_a10 | output | 1 | Address bit 10, high selects all banks |

## Verification
A wrong counter value shows at the ports one interval later: `rfsh_req` rises at a cycle other than the one the rate and the last observed refresh or freeze predict. This is checked to the exact cycle. A sequencer in the wrong state shows at once as a command in the wrong cycle, for example a precharge that ignores `bus_idle`, a refresh spaced other than TRP, or traffic inside the TRC window. A pending flag that is lost or doubled shows as a missing or extra refresh once mastership returns.

// File: rtl/rfsh_pkg.sv
// Shared types and helpers for the synchronized refresh timer.
// Assumes the SDRAM command encoding of chip select, row/column strobes and write enable.
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_STOP = 3'd1,
        ST_WAIT = 3'd2,
        ST_PRE  = 3'd3,
        ST_TRPW = 3'd4,
        ST_REF  = 3'd5,
        ST_TRCW = 3'd6
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam sd_cmd_t CMD_BST  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0, a10: 1'b0};
    localparam sd_cmd_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
    localparam sd_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b1};

    // Largest of four interval counts, used to size the counter.
    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rfsh_snoop_decode.sv
// Decodes refresh and self-refresh entry from the snooped shared command pins.
// Assumes the pins are already synchronous to clk; keeps one cycle of clock-enable history.
module rfsh_snoop_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic snp_cke,
    input  logic snp_cs_n,
    input  logic snp_ras_n,
    input  logic snp_cas_n,
    input  logic snp_we_n,
    output logic ref_seen,
    output logic sref_entry
);

    logic cke_prev_q;
    logic ref_code;

    // Remember the clock-enable of the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_prev_q <= 1'b1;
        else        cke_prev_q <= snp_cke;
    end

    // Classify the refresh encoding by the clock-enable transition.
    always_comb begin
        ref_code   = !snp_cs_n && !snp_ras_n && !snp_cas_n && snp_we_n;
        ref_seen   = ref_code && cke_prev_q && snp_cke;
        sref_entry = ref_code && cke_prev_q && !snp_cke;
    end

endmodule

// File: rtl/rfsh_interval_timer.sv
// Interval down-counter with pending-request flag.
// Slave mode reloads on observed refresh; any mode freezes while snooped clock-enable is low
// after a self-refresh entry. Assumes rate_sel is static between resets.
module rfsh_interval_timer #(
    parameter int unsigned PER0  = 600,
    parameter int unsigned PER1  = 900,
    parameter int unsigned PER2  = 1200,
    parameter int unsigned PER3  = 2400,
    parameter int unsigned CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    input  logic       is_master,
    input  logic       ref_seen,
    input  logic       sref_entry,
    input  logic       snp_cke,
    input  logic       ref_issued,
    output logic       pending
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_m1;
    logic             frozen_q;
    logic             cnt_en;
    logic             slave_ref;
    logic             expire;

    // Select the reload value (interval minus one).
    always_comb begin
        unique case (rate_sel)
            2'b00:   per_m1 = CNT_W'(PER0 - 1);
            2'b01:   per_m1 = CNT_W'(PER1 - 1);
            2'b10:   per_m1 = CNT_W'(PER2 - 1);
            default: per_m1 = CNT_W'(PER3 - 1);
        endcase
    end

    // Counting is held on the entry cycle and on every frozen cycle with clock-enable low.
    always_comb begin
        cnt_en    = !(sref_entry || (frozen_q && !snp_cke));
        slave_ref = !is_master && ref_seen;
        expire    = cnt_en && !slave_ref && (cnt_q == '0);
    end

    // Track the self-refresh freeze window.
    always_ff @(posedge clk) begin
        if (!rst_n)          frozen_q <= 1'b0;
        else if (sref_entry) frozen_q <= 1'b1;
        else if (snp_cke)    frozen_q <= 1'b0;
    end

    // Interval counter: reload on observed refresh or expiry, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= per_m1;
        else if (slave_ref)           cnt_q <= per_m1;
        else if (cnt_en) begin
            if (cnt_q == '0)          cnt_q <= per_m1;
            else                      cnt_q <= cnt_q - 1'b1;
        end
    end

    // Pending request: set by expiry, cleared by own or observed refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pending <= 1'b0;
        else if (expire)                    pending <= 1'b1;
        else if (ref_issued || slave_ref)   pending <= 1'b0;
    end

    a_r1_expiry_sets_request: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pending);

    a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ref_issued && !slave_ref) |=> pending);

    a_r8_reload_on_observed: assert property (@(posedge clk) disable iff (!rst_n)
        slave_ref |=> (cnt_q == $past(per_m1)));

    a_r9_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sref_entry || (frozen_q && !snp_cke)) |=> $stable(cnt_q));

endmodule

// File: rtl/rfsh_seq_fsm.sv
// Command sequencer: optional burst-stop, precharge-all, TRP wait, one refresh, TRC guard.
// Assumes TRP >= 2 and TRAS >= 2; returns to idle at once if mastership is lost.
module rfsh_seq_fsm
    import rfsh_pkg::*;
#(
    parameter int unsigned TRP  = 3,
    parameter int unsigned TRAS = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pending,
    input  logic    is_master,
    input  logic    bus_idle,
    output logic    ref_issued,
    output logic    busy,
    output logic    drive,
    output sd_cmd_t cmd
);

    localparam int unsigned TRC    = TRAS + TRP;
    localparam int unsigned WAIT_W = $clog2(TRC + 1);

    seq_state_t        state_q, state_d;
    logic [WAIT_W-1:0] wcnt_q, wcnt_d;

    // Next-state and wait-counter logic.
    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        if (state_q != ST_IDLE && !is_master) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (pending && is_master) state_d = bus_idle ? ST_PRE : ST_STOP;
                ST_STOP: state_d = ST_WAIT;
                ST_WAIT: if (bus_idle) state_d = ST_PRE;
                ST_PRE: begin
                    state_d = ST_TRPW;
                    wcnt_d  = WAIT_W'(TRP - 2);
                end
                ST_TRPW: begin
                    if (wcnt_q == '0) state_d = ST_REF;
                    else              wcnt_d  = wcnt_q - 1'b1;
                end
                ST_REF: begin
                    state_d = ST_TRCW;
                    wcnt_d  = WAIT_W'(TRC - 2);
                end
                ST_TRCW: begin
                    if (wcnt_q == '0) state_d = ST_IDLE;
                    else              wcnt_d  = wcnt_q - 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State and wait-counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
        end
    end

    // Decode command and flags from the registered state.
    always_comb begin
        unique case (state_q)
            ST_STOP: cmd = CMD_BST;
            ST_PRE:  cmd = CMD_PREA;
            ST_REF:  cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
        busy       = (state_q != ST_IDLE);
        drive      = busy && is_master;
        ref_issued = (state_q == ST_REF) && is_master;
    end

    a_r3_stop_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && is_master) |=> (state_q == ST_WAIT));

    a_r4_ref_after_trp: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REF) |-> ($past(state_q) == ST_TRPW));

    a_r5_guard_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRCW) |=> (state_q == ST_TRCW || state_q == ST_IDLE));

endmodule

// File: rtl/sdram_refresh_sync.sv
// Top of the synchronized refresh timer: snoop decoder, interval timer and sequencer.
// Assumes one controller at a time holds is_master and that all share the same rate and timings.
module sdram_refresh_sync
    import rfsh_pkg::*;
#(
    parameter int unsigned PER0 = 600,
    parameter int unsigned PER1 = 900,
    parameter int unsigned PER2 = 1200,
    parameter int unsigned PER3 = 2400,
    parameter int unsigned TRP  = 3,
    parameter int unsigned TRAS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    input  logic       is_master,
    input  logic       bus_idle,
    input  logic       snp_cke,
    input  logic       snp_cs_n,
    input  logic       snp_ras_n,
    input  logic       snp_cas_n,
    input  logic       snp_we_n,
    output logic       rfsh_req,
    output logic       busy,
    output logic       cmd_oe,
    output logic       cmd_cs_n,
    output logic       cmd_ras_n,
    output logic       cmd_cas_n,
    output logic       cmd_we_n,
    output logic       cmd_a10
);

    localparam int unsigned PER_MAX = max4(PER0, PER1, PER2, PER3);
    localparam int unsigned CNT_W   = $clog2(PER_MAX);

    logic    ref_seen;
    logic    sref_entry;
    logic    pending;
    logic    ref_issued;
    logic    drive;
    sd_cmd_t cmd;

    rfsh_snoop_decode i_snoop (
        .clk        (clk),
        .rst_n      (rst_n),
        .snp_cke    (snp_cke),
        .snp_cs_n   (snp_cs_n),
        .snp_ras_n  (snp_ras_n),
        .snp_cas_n  (snp_cas_n),
        .snp_we_n   (snp_we_n),
        .ref_seen   (ref_seen),
        .sref_entry (sref_entry)
    );

    rfsh_interval_timer #(
        .PER0  (PER0),
        .PER1  (PER1),
        .PER2  (PER2),
        .PER3  (PER3),
        .CNT_W (CNT_W)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel   (rate_sel),
        .is_master  (is_master),
        .ref_seen   (ref_seen),
        .sref_entry (sref_entry),
        .snp_cke    (snp_cke),
        .ref_issued (ref_issued),
        .pending    (pending)
    );

    rfsh_seq_fsm #(
        .TRP  (TRP),
        .TRAS (TRAS)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .is_master  (is_master),
        .bus_idle   (bus_idle),
        .ref_issued (ref_issued),
        .busy       (busy),
        .drive      (drive),
        .cmd        (cmd)
    );

    // Drive the port-level outputs.
    always_comb begin
        rfsh_req  = pending;
        cmd_oe    = drive;
        cmd_cs_n  = drive ? cmd.cs_n : 1'b1;
        cmd_ras_n = cmd.ras_n;
        cmd_cas_n = cmd.cas_n;
        cmd_we_n  = cmd.we_n;
        cmd_a10   = cmd.a10;
    end

    a_r7_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (!cmd_oe && cmd_cs_n));

    a_r6_ref_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        ref_issued |-> rfsh_req);

endmodule

// File: tb/test_sdram_refresh_sync.sv
// Directed bench for the synchronized refresh timer; one task per scenario.
module test_sdram_refresh_sync;

    localparam int TRP  = 3;
    localparam int TRAS = 4;
    localparam int TRC  = TRP + TRAS;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] rate_sel;
    logic       is_master;
    logic       bus_idle;
    logic       snp_cke, snp_cs_n, snp_ras_n, snp_cas_n, snp_we_n;
    logic       rfsh_req, busy, cmd_oe;
    logic       cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    sdram_refresh_sync #(.TRP(TRP), .TRAS(TRAS)) i_sdram_refresh_sync (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .is_master(is_master),
        .bus_idle(bus_idle), .snp_cke(snp_cke), .snp_cs_n(snp_cs_n),
        .snp_ras_n(snp_ras_n), .snp_cas_n(snp_cas_n), .snp_we_n(snp_we_n),
        .rfsh_req(rfsh_req), .busy(busy), .cmd_oe(cmd_oe), .cmd_cs_n(cmd_cs_n),
        .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
        .cmd_a10(cmd_a10)
    );

    always #4 clk = ~clk;

    function automatic bit is_ref();
        return cmd_oe && !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && cmd_we_n && cmd_a10;
    endfunction
    function automatic bit is_prea();
        return cmd_oe && !cmd_cs_n && !cmd_ras_n && cmd_cas_n && !cmd_we_n && cmd_a10;
    endfunction
    function automatic bit is_bst();
        return cmd_oe && !cmd_cs_n && cmd_ras_n && cmd_cas_n && !cmd_we_n;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic snoop_nop();
        snp_cs_n = 1'b1; snp_ras_n = 1'b1; snp_cas_n = 1'b1; snp_we_n = 1'b1;
    endtask

    task automatic snoop_ref(input logic cke);
        snp_cs_n = 1'b0; snp_ras_n = 1'b0; snp_cas_n = 1'b0; snp_we_n = 1'b1;
        snp_cke  = cke;
    endtask

    task automatic do_reset(input logic [1:0] rate, input logic master);
        rst_n = 1'b0; rate_sel = rate; is_master = master; bus_idle = 1'b1;
        snp_cke = 1'b1; snoop_nop();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Step negedges until the condition picked by sel holds; returns steps taken.
    task automatic steps_until(input int sel, input int limit, output int n);
        bit hit;
        n = 0;
        hit = 0;
        while (!hit && n < limit) begin
            @(negedge clk);
            n++;
            case (sel)
                0: hit = is_ref();
                1: hit = rfsh_req;
                2: hit = !busy;
                default: hit = 1'b1;
            endcase
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0; rate_sel = 2'b00; is_master = 1'b1; bus_idle = 1'b1;
        snp_cke = 1'b1; snoop_nop();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 rfsh_req in reset", int'(rfsh_req), 0);
        check("R11 busy in reset", int'(busy), 0);
        check("R11 cmd_oe in reset", int'(cmd_oe), 0);
        check("R11 cs_n in reset", int'(cmd_cs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 rfsh_req after reset", int'(rfsh_req), 0);
        check("R11 cmd_oe after reset", int'(cmd_oe), 0);
    endtask

    task automatic t_period(input logic [1:0] rate, input int per);
        int n;
        do_reset(rate, 1'b1);
        steps_until(0, per + 50, n);
        check("R1 first refresh found", int'(is_ref()), 1);
        steps_until(0, per + 50, n);
        check($sformatf("R1 interval rate=%0d", rate), n, per);
    endtask

    task automatic t_sequence();
        int  n;
        bit  quiet;
        do_reset(2'b00, 1'b1);
        steps_until(1, 700, n);
        check("R2 request rises at expiry", n, 600);
        check("R2 no command with request", int'(cmd_oe), 0);
        @(negedge clk);
        check("R4 precharge-all next cycle", int'(is_prea()), 1);
        steps_until(0, 20, n);
        check("R4 precharge to refresh gap", n, TRP);
        @(negedge clk);
        check("R2 request falls after refresh", int'(rfsh_req), 0);
        quiet = 1;
        n = 1;
        while (busy && n < 40) begin
            if (!cmd_cs_n) quiet = 0;
            @(negedge clk);
            n++;
        end
        check("R5 busy falls TRC after refresh", n, TRC);
        check("R5 only no-op in guard window", int'(quiet), 1);
    endtask

    task automatic t_burst_stop();
        int n;
        do_reset(2'b00, 1'b1);
        bus_idle = 1'b0;
        steps_until(1, 700, n);
        @(negedge clk);
        check("R3 burst-stop after request", int'(is_bst()), 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R3 no command while burst open", int'(cmd_cs_n), 1);
        end
        bus_idle = 1'b1;
        @(negedge clk);
        check("R4 precharge-all after bus idle", int'(is_prea()), 1);
        steps_until(0, 20, n);
        check("R4 gap after burst-stop path", n, TRP);
    endtask

    task automatic t_slave_sync();
        int n;
        bit drove;
        do_reset(2'b00, 1'b0);
        drove = 0;
        n = 0;
        while (!rfsh_req && n < 700) begin
            @(negedge clk);
            n++;
            if (cmd_oe || !cmd_cs_n) drove = 1;
        end
        check("R2 slave request at expiry", n, 600);
        check("R7 slave never drives", int'(drove), 0);
        snoop_ref(1'b1);
        @(negedge clk);
        snoop_nop();
        @(negedge clk);
        check("R8 observed refresh clears request", int'(rfsh_req), 0);
        steps_until(1, 700, n);
        check("R8 reload gives full interval", n + 1, 600);
    endtask

    task automatic t_freeze(input int frz);
        int n;
        do_reset(2'b00, 1'b0);
        repeat (20) @(negedge clk);
        snoop_ref(1'b1);
        @(negedge clk);
        snoop_nop();
        n = 0;
        while (!rfsh_req && n < 2000) begin
            if (n == 50) snoop_ref(1'b0);
            if (n == 51) snoop_nop();
            if (n == 50 + frz) snp_cke = 1'b1;
            @(negedge clk);
            n++;
        end
        check("R9 freeze delays expiry", n, 600 + frz);
    endtask

    task automatic t_pending_master();
        int  n;
        int  refs;
        bit  drove;
        do_reset(2'b00, 1'b0);
        drove = 0;
        for (int i = 0; i < 1800; i++) begin
            @(negedge clk);
            if (cmd_oe) drove = 1;
        end
        check("R7 slave quiet across expiries", int'(drove), 0);
        check("R10 request held while slave", int'(rfsh_req), 1);
        is_master = 1'b1;
        @(negedge clk);
        check("R10 precharge-all after mastership", int'(is_prea()), 1);
        steps_until(0, 20, n);
        check("R6 refresh issued", int'(is_ref()), 1);
        refs = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (is_ref()) refs++;
        end
        check("R6 merged expiries give one refresh", refs, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_period(2'b00, 600);
        t_period(2'b01, 900);
        t_period(2'b10, 1200);
        t_period(2'b11, 2400);
        t_sequence();
        t_burst_stop();
        t_slave_sync();
        t_freeze(100);
        t_freeze(1);
        t_pending_master();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule